// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block recovers asynchronous serial characters from a single receive line. An external baud generator supplies an oversampling strobe at either 16 or 8 times the bit rate, and a configuration input selects which ratio applies. A falling edge on the idle-high line, confirmed low at the middle of the start bit, opens a frame. The block then shifts in 8 or 9 data positions, least significant first, and one stop bit. Each bit is decided either by voting on three samples around the bit centre or by taking the centre sample alone. In the voting mode, samples that disagree are reported as noise.

A finished word goes into a holding register, and a full flag rises. Error flags report a lost word (overrun), line noise, a bad stop bit (framing) and a parity mismatch. A separate flag reports a quiet line after traffic. A data read clears the full flag. The error flags and the quiet-line flag clear only when a status read strobe is followed later by a data read strobe. An active-low ready-to-send output can signal the sender to pause while the holding register is occupied.

Top module: `ovs_rx_top`

## Requirements
- R1: With `cfg_os8`=0 a bit lasts 16 strobes and is sampled at strobes 8, 9 and 10 of the bit. With `cfg_os8`=1 a bit lasts 8 strobes and is sampled at strobes 4, 5 and 6. Strobe 1 of the start bit is the first strobe that sees the line low after it was high.
- R2: With `cfg_single`=0 each bit takes the majority of its three samples. If the three samples are not all equal, `flg_nf` is set in the same cycle that `flg_rxne` rises.
- R3: With `cfg_single`=1 each bit takes only the middle sample (9 at 16x, 5 at 8x), and `flg_nf` is never set.
- R4: A frame is one low start bit, then N data positions received LSB first into `rd_data[N-1:0]` (N=9 when `cfg_nine`=1, else N=8 with `rd_data[8]`=0), then one stop bit. A completed frame loads `rd_data` and sets `flg_rxne`. A `data_rd` pulse clears `flg_rxne`.
- R5: With `cfg_par_en`=1 the top received position (bit N-1) is the parity bit. `flg_pe` is set when the count of ones over all N positions is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1.
- R6: A stop bit decided as 0 sets `flg_fe`. An all-zero break frame therefore gives `flg_fe`=1 with `rd_data`=0 loaded.
- R7: If a frame completes while `flg_rxne` is 1, `flg_ore` is set and `rd_data` keeps its earlier value. The new word is discarded.
- R8: `flg_ore`, `flg_nf`, `flg_fe`, `flg_pe` and `flg_idle` clear only when a `stat_rd` pulse is followed by a `data_rd` pulse. A `data_rd` pulse with no `stat_rd` before it leaves them set.
- R9: If the start bit is decided high at its centre, the frame is abandoned and nothing is loaded.
- R10: After a completed frame, `flg_idle` is set on the (N+2)·R-th consecutive high strobe, where R is the oversampling ratio. It is not set before that strobe.
- R11: With `cfg_rts_en`=1, `rts_n` equals `flg_rxne`: low while a word can be accepted, high while the holding register is full. With `cfg_rts_en`=0, `rts_n` stays low.
- R12: After reset, `rd_data` is 0, every flag is 0 and `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, one cycle wide |
| rx_in | input | 1 | Serial receive line, idle high |
| cfg_os8 | input | 1 | 1: 8x oversampling, 0: 16x |
| cfg_single | input | 1 | 1: centre sample only, 0: three-sample vote |
| cfg_nine | input | 1 | 1: 9 data positions, 0: 8 |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_rts_en | input | 1 | Ready-to-send output enable |
| stat_rd | input | 1 | Status read strobe (arms flag clear) |
| data_rd | input | 1 | Data read strobe |
| rd_data | output | 9 | Received word holding register |
| flg_rxne | output | 1 | Holding register full |
| flg_ore | output | 1 | Overrun |
| flg_nf | output | 1 | Noise seen in the loaded frame |
| flg_fe | output | 1 | Framing error |
| flg_pe | output | 1 | Parity error |
| flg_idle | output | 1 | Quiet line after traffic |
| rts_n | output | 1 | Active-low ready to send |

## Verification
The line reaches the sampler through two synchronizer flops. A sample is therefore taken at the first strobe that arrives at least two clocks after the line changes. A frame's word and flags reach the ports two clocks after the strobe that samples the stop-bit centre: one clock in the frame sequencer and one in the flag register. The read strobes act at the next clock edge. The bench holds each oversampling slot for three clocks with the strobe on the third, so every sample lands on a known slot. It checks frame results one full slot after the stop bit ends, and read effects one falling edge after the strobe, which is well past each due cycle.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  localparam int unsigned WORD_MAX = 9;
  localparam int unsigned OSR_MAX  = 16;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/ovs_rx_sync.sv
module ovs_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] tap;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic d_in;
    logic q;
    if (g == 0) begin : g_first
      assign d_in = din;
    end else begin : g_next
      assign d_in = tap[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d_in;
    end
    assign tap[g] = q;
  end

  assign dout = tap[STAGES-1];
endmodule

// File: rtl/ovs_rx_vote.sv
module ovs_rx_vote #(
  parameter int unsigned OSR_HI = 16,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             smp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_os8,
  input  logic             cfg_single,
  output logic             bit_val,
  output logic             bit_noise
);
  localparam logic [CNT_W-1:0] POS_HI = CNT_W'(OSR_HI / 2);
  localparam logic [CNT_W-1:0] POS_LO = CNT_W'(OSR_HI / 4);

  logic [CNT_W-1:0] pos_a;
  logic a_q, a_d, b_q, b_d;
  logic maj;

  assign pos_a = cfg_os8 ? POS_LO : POS_HI;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (tick && (cnt == pos_a))                  a_d = smp;
    if (tick && (cnt == pos_a + CNT_W'(1)))      b_d = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // third sample is the live one at the decision strobe
  assign maj       = (a_q & b_q) | (a_q & smp) | (b_q & smp);
  assign bit_val   = cfg_single ? b_q : maj;
  assign bit_noise = !cfg_single && !((a_q == b_q) && (b_q == smp));
endmodule

// File: rtl/ovs_rx_framer.sv
module ovs_rx_framer
  import ovs_rx_pkg::*;
#(
  parameter int unsigned OSR_HI = 16,
  parameter int unsigned WORD_W = 9,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              smp,
  input  logic              cfg_os8,
  input  logic              cfg_single,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              v_val,
  input  logic              v_noise,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              noise_o,
  output logic              ferr_o,
  output logic              perr_o,
  output logic              idle_o
);
  localparam int unsigned BIDX_W = $clog2(WORD_W);
  localparam int unsigned IDL_W  = $clog2((WORD_W + 2) * OSR_HI + 1);
  localparam logic [CNT_W-1:0] OSR_H = CNT_W'(OSR_HI);
  localparam logic [CNT_W-1:0] OSR_L = CNT_W'(OSR_HI / 2);
  localparam logic [CNT_W-1:0] DEC_H = CNT_W'(OSR_HI / 2 + 2);
  localparam logic [CNT_W-1:0] DEC_L = CNT_W'(OSR_HI / 4 + 2);

  rx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIDX_W-1:0]  bidx_q, bidx_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic               nacc_q, nacc_d;
  logic               prev_q, prev_d;
  logic               done_q, done_d;
  logic               noise_q, noise_d;
  logic               ferr_q, ferr_d;
  logic               perr_q, perr_d;
  logic               armed_q, armed_d;
  logic [IDL_W-1:0]   icnt_q, icnt_d;
  logic               idle_q, idle_d;

  logic [CNT_W-1:0]   osr, dec_pos;
  logic [BIDX_W-1:0]  last_idx;
  logic [IDL_W-1:0]   idle_bits, idle_thr;

  assign osr       = cfg_os8 ? OSR_L : OSR_H;
  assign dec_pos   = cfg_os8 ? DEC_L : DEC_H;
  assign last_idx  = cfg_nine ? BIDX_W'(WORD_W - 1) : BIDX_W'(WORD_W - 2);
  assign idle_bits = cfg_nine ? IDL_W'(WORD_W + 2) : IDL_W'(WORD_W + 1);
  assign idle_thr  = IDL_W'(idle_bits * IDL_W'(osr));

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    word_d  = word_q;
    nacc_d  = nacc_q;
    prev_d  = prev_q;
    done_d  = 1'b0;
    noise_d = noise_q;
    ferr_d  = ferr_q;
    perr_d  = perr_q;
    armed_d = armed_q;
    icnt_d  = icnt_q;
    idle_d  = 1'b0;
    if (tick) begin
      prev_d = smp;
      if (st_q == RX_IDLE) begin
        if (armed_q && smp) begin
          if (icnt_q == idle_thr - IDL_W'(1)) begin
            idle_d  = 1'b1;
            armed_d = 1'b0;
            icnt_d  = '0;
          end else begin
            icnt_d = icnt_q + IDL_W'(1);
          end
        end else begin
          icnt_d = '0;
        end
        if (prev_q && !smp) begin
          st_d   = RX_START;
          cnt_d  = CNT_W'(2);
          nacc_d = 1'b0;
          word_d = '0;
          bidx_d = '0;
          icnt_d = '0;
        end
      end else begin
        cnt_d = (cnt_q == osr) ? CNT_W'(1) : cnt_q + CNT_W'(1);
        if (cnt_q == dec_pos) begin
          nacc_d = nacc_q | v_noise;
          unique case (st_q)
            RX_START: if (v_val) st_d = RX_IDLE;
            RX_DATA:  word_d[bidx_q] = v_val;
            RX_STOP: begin
              done_d  = 1'b1;
              ferr_d  = !v_val;
              noise_d = nacc_q | v_noise;
              perr_d  = cfg_par_en & ((^word_q) ^ cfg_par_odd);
              armed_d = 1'b1;
              icnt_d  = '0;
              st_d    = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == osr) begin
          if (st_q == RX_START) begin
            st_d   = RX_DATA;
            bidx_d = '0;
          end else if (st_q == RX_DATA) begin
            if (bidx_q == last_idx) st_d = RX_STOP;
            else                    bidx_d = bidx_q + BIDX_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      word_q  <= '0;
      nacc_q  <= 1'b0;
      prev_q  <= 1'b1;
      done_q  <= 1'b0;
      noise_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      armed_q <= 1'b0;
      icnt_q  <= '0;
      idle_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      word_q  <= word_d;
      nacc_q  <= nacc_d;
      prev_q  <= prev_d;
      done_q  <= done_d;
      noise_q <= noise_d;
      ferr_q  <= ferr_d;
      perr_q  <= perr_d;
      armed_q <= armed_d;
      icnt_q  <= icnt_d;
      idle_q  <= idle_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign done_o  = done_q;
  assign word_o  = word_q;
  assign noise_o = noise_q;
  assign ferr_o  = ferr_q;
  assign perr_o  = perr_q;
  assign idle_o  = idle_q;

  // completion is a single-cycle event (R4)
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // centre-sample mode never reports noise (R3)
  assert_single_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && cfg_single) |-> !noise_q);
  // the quiet-line event only fires from the idle state (R10)
  assert_idle_in_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> (st_q == RX_IDLE || st_q == RX_START));
endmodule

// File: rtl/ovs_rx_flags.sv
module ovs_rx_flags #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              noise,
  input  logic              ferr,
  input  logic              perr,
  input  logic              idle_hit,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              cfg_rts_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rxne,
  output logic              ore,
  output logic              nf,
  output logic              fe,
  output logic              pe,
  output logic              idle,
  output logic              rts_n
);
  logic [WORD_W-1:0] data_q, data_d;
  logic rxne_q, rxne_d, ore_q, ore_d, nf_q, nf_d;
  logic fe_q, fe_d, pe_q, pe_d, idle_q, idle_d, seq_q, seq_d;
  logic accept, ovr, clr;

  always_comb begin
    clr    = data_rd & seq_q;
    accept = done & (!rxne_q | data_rd);
    ovr    = done & rxne_q & !data_rd;
    seq_d  = stat_rd ? 1'b1 : (data_rd ? 1'b0 : seq_q);
    rxne_d = accept | (rxne_q & !data_rd);
    data_d = accept ? word : data_q;
    ore_d  = ovr | (ore_q & !clr);
    nf_d   = (accept & noise) | (nf_q & !clr);
    fe_d   = (accept & ferr) | (fe_q & !clr);
    pe_d   = (accept & perr) | (pe_q & !clr);
    idle_d = idle_hit | (idle_q & !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rxne_q <= 1'b0;
      ore_q  <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      idle_q <= 1'b0;
      seq_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rxne_q <= rxne_d;
      ore_q  <= ore_d;
      nf_q   <= nf_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      idle_q <= idle_d;
      seq_q  <= seq_d;
    end
  end

  assign rd_data = data_q;
  assign rxne    = rxne_q;
  assign ore     = ore_q;
  assign nf      = nf_q;
  assign fe      = fe_q;
  assign pe      = pe_q;
  assign idle    = idle_q;
  assign rts_n   = cfg_rts_en & rxne_q;

  // a word arriving into a full register is dropped, old word kept (R7)
  assert_ovr_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rxne_q && !data_rd) |=> (ore_q && (data_q == $past(data_q))));
  // noise is only ever reported alongside a loaded word (R2)
  assert_nf_with_rxne_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_q) |-> rxne_q);
  // an armed data read empties every error flag (R8)
  assert_seq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && seq_q && !done && !idle_hit) |=> (!ore_q && !nf_q && !fe_q && !pe_q && !idle_q));
  // full flag rises only after a completed frame (R4)
  assert_rxne_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxne_q) |-> $past(done));
endmodule

// File: rtl/ovs_rx_top.sv
module ovs_rx_top
  import ovs_rx_pkg::*;
#(
  parameter int unsigned OSR_HI      = OSR_MAX,
  parameter int unsigned WORD_W      = WORD_MAX,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_in,
  input  logic              cfg_os8,
  input  logic              cfg_single,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_rts_en,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [WORD_W-1:0] rd_data,
  output logic              flg_rxne,
  output logic              flg_ore,
  output logic              flg_nf,
  output logic              flg_fe,
  output logic              flg_pe,
  output logic              flg_idle,
  output logic              rts_n
);
  localparam int unsigned CNT_W = $clog2(OSR_HI + 1);

  logic              rst_n_s;
  logic              rx_s;
  logic [CNT_W-1:0]  cnt;
  logic              v_val, v_noise;
  logic              done, noise, ferr, perr, idle_hit;
  logic [WORD_W-1:0] word;

  ovs_rx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_n_s));

  ovs_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n_s), .din(rx_in), .dout(rx_s));

  ovs_rx_vote #(.OSR_HI(OSR_HI), .CNT_W(CNT_W)) u_vote (
    .clk(clk), .rst_n(rst_n_s), .tick(os_tick), .smp(rx_s), .cnt(cnt),
    .cfg_os8(cfg_os8), .cfg_single(cfg_single),
    .bit_val(v_val), .bit_noise(v_noise));

  ovs_rx_framer #(.OSR_HI(OSR_HI), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n_s), .tick(os_tick), .smp(rx_s),
    .cfg_os8(cfg_os8), .cfg_single(cfg_single), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .v_val(v_val), .v_noise(v_noise), .cnt_o(cnt), .done_o(done),
    .word_o(word), .noise_o(noise), .ferr_o(ferr), .perr_o(perr),
    .idle_o(idle_hit));

  ovs_rx_flags #(.WORD_W(WORD_W)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .done(done), .word(word), .noise(noise),
    .ferr(ferr), .perr(perr), .idle_hit(idle_hit), .stat_rd(stat_rd),
    .data_rd(data_rd), .cfg_rts_en(cfg_rts_en), .rd_data(rd_data),
    .rxne(flg_rxne), .ore(flg_ore), .nf(flg_nf), .fe(flg_fe), .pe(flg_pe),
    .idle(flg_idle), .rts_n(rts_n));
endmodule

// File: tb/sim_ovs_rx_top.sv
module sim_ovs_rx_top;
  logic clk, rst_n, os_tick, rx_in;
  logic cfg_os8, cfg_single, cfg_nine, cfg_par_en, cfg_par_odd, cfg_rts_en;
  logic stat_rd, data_rd;
  logic [8:0] rd_data;
  logic flg_rxne, flg_ore, flg_nf, flg_fe, flg_pe, flg_idle, rts_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  ovs_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .cfg_os8(cfg_os8), .cfg_single(cfg_single), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_rts_en(cfg_rts_en),
    .stat_rd(stat_rd), .data_rd(data_rd), .rd_data(rd_data),
    .flg_rxne(flg_rxne), .flg_ore(flg_ore), .flg_nf(flg_nf), .flg_fe(flg_fe),
    .flg_pe(flg_pe), .flg_idle(flg_idle), .rts_n(rts_n));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       os8;
    logic       single;
    logic       nine;
    logic       pen;
    logic       podd;
    logic [8:0] word;
    logic [3:0] gbit;   // 0 start, 1..N data, N+1 stop, 15 none
    logic [4:0] gslot;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h035, 4'd15, 5'd0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0CA, 4'd3,  5'd5},
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1A5, 4'd2,  5'd8},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'h035, 4'd15, 5'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h035, 4'd15, 5'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0F3, 4'd0,  5'd4},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 9'h101, 4'd10, 5'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rx_in = v;
    os_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
  endtask

  task automatic drive_bit(input logic v, input int gslot);
    int n;
    n = cfg_os8 ? 8 : 16;
    for (int s = 1; s <= n; s++) slot((s == gslot) ? ~v : v);
  endtask

  task automatic send_frame(input logic [8:0] w, input int gbit, input int gslot, input logic stopv);
    int n;
    n = cfg_nine ? 9 : 8;
    drive_bit(1'b0, (gbit == 0) ? gslot : 0);
    for (int i = 0; i < n; i++) drive_bit(w[i], (gbit == i + 1) ? gslot : 0);
    drive_bit(stopv, (gbit == n + 1) ? gslot : 0);
    slot(1'b1);
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_data();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b0; rx_in = 1'b1;
    cfg_os8 = 1'b0; cfg_single = 1'b0; cfg_nine = 1'b0;
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_rts_en = 1'b1;
    stat_rd = 1'b0; data_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 rd_data", 32'(rd_data), 0);
    chk("R12 rxne", 32'(flg_rxne), 0);
    chk("R12 err flags", 32'({flg_ore, flg_nf, flg_fe, flg_pe, flg_idle}), 0);
    chk("R12 rts_n", 32'(rts_n), 0);
    cfg_rts_en = 1'b0;

    // table of frames: R1 ratio, R2 vote, R3 centre sample, R4 data, R5 parity
    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] ed;
      logic epe, enf;
      cfg_os8 = VECS[i].os8; cfg_single = VECS[i].single; cfg_nine = VECS[i].nine;
      cfg_par_en = VECS[i].pen; cfg_par_odd = VECS[i].podd;
      ed  = VECS[i].nine ? VECS[i].word : {1'b0, VECS[i].word[7:0]};
      epe = VECS[i].pen && ((^ed) != VECS[i].podd);
      enf = (VECS[i].gbit != 4'd15) && !VECS[i].single;
      slot(1'b1); slot(1'b1);
      send_frame(VECS[i].word, int'(VECS[i].gbit), int'(VECS[i].gslot), 1'b1);
      chk($sformatf("R1 R4 vec%0d data", i), 32'(rd_data), 32'(ed));
      chk($sformatf("R4 vec%0d rxne", i), 32'(flg_rxne), 1);
      chk($sformatf("R2 R3 vec%0d nf", i), 32'(flg_nf), 32'(enf));
      chk($sformatf("R5 vec%0d pe", i), 32'(flg_pe), 32'(epe));
      chk($sformatf("R6 vec%0d fe", i), 32'(flg_fe), 0);
      pulse_stat();
      pulse_data();
      chk($sformatf("R4 R8 vec%0d cleared", i), 32'({flg_rxne, flg_nf, flg_pe, flg_ore}), 0);
    end

    cfg_os8 = 1'b0; cfg_single = 1'b0; cfg_nine = 1'b0;
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R7 overrun keeps the first word
    slot(1'b1); slot(1'b1);
    send_frame(9'h011, 15, 0, 1'b1);
    slot(1'b1);
    send_frame(9'h022, 15, 0, 1'b1);
    chk("R7 ore", 32'(flg_ore), 1);
    chk("R7 data kept", 32'(rd_data), 32'h011);
    chk("R7 rxne", 32'(flg_rxne), 1);
    // R8 data read alone does not clear errors
    pulse_data();
    chk("R8 rxne cleared by read", 32'(flg_rxne), 0);
    chk("R8 ore held without status read", 32'(flg_ore), 1);
    pulse_stat();
    pulse_data();
    chk("R8 ore cleared by sequence", 32'(flg_ore), 0);

    // R6 break frame
    slot(1'b1); slot(1'b1);
    send_frame(9'h000, 15, 0, 1'b0);
    chk("R6 break fe", 32'(flg_fe), 1);
    chk("R6 break data", 32'(rd_data), 0);
    chk("R6 break rxne", 32'(flg_rxne), 1);
    pulse_stat();
    pulse_data();
    chk("R8 fe cleared", 32'(flg_fe), 0);

    // R9 false start: low for 7 strobes only
    slot(1'b1); slot(1'b1);
    for (int s = 0; s < 7; s++) slot(1'b0);
    for (int s = 0; s < 20; s++) slot(1'b1);
    chk("R9 no load", 32'(flg_rxne), 0);
    send_frame(9'h05A, 15, 0, 1'b1);
    chk("R9 recovers data", 32'(rd_data), 32'h05A);
    pulse_data();

    // R11 ready-to-send
    cfg_rts_en = 1'b1;
    @(negedge clk);
    chk("R11 rts low when empty", 32'(rts_n), 0);
    slot(1'b1);
    send_frame(9'h0A5, 15, 0, 1'b1);
    chk("R11 rts high when full", 32'(rts_n), 1);
    cfg_rts_en = 1'b0;
    @(negedge clk);
    chk("R11 rts low when disabled", 32'(rts_n), 0);
    cfg_rts_en = 1'b1;
    pulse_data();
    chk("R11 rts low after read", 32'(rts_n), 0);

    // R10 quiet line: 8-bit 16x needs 160 high strobes after stop centre
    slot(1'b1);
    send_frame(9'h03C, 15, 0, 1'b1);
    pulse_data();
    for (int s = 0; s < 100; s++) slot(1'b1);
    chk("R10 idle not yet", 32'(flg_idle), 0);
    for (int s = 0; s < 60; s++) slot(1'b1);
    chk("R10 idle set", 32'(flg_idle), 1);
    pulse_data();
    chk("R8 idle held by lone read", 32'(flg_idle), 1);
    pulse_stat();
    pulse_data();
    chk("R8 idle cleared", 32'(flg_idle), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule